// File: doc/BRIEF.md
# Clock-Rate Change Sequencer for DRAM Power-Down

This block sits on the memory-controller side of a DDR-style DRAM channel and walks the memory through a clock-rate change. When a change is requested and the controller reports that all banks are precharged, the sequencer takes over the clock-enable, termination and command pins. It first shuts termination off and waits, then lowers clock enable to enter precharge power-down. After the entry delay it asks the external clock generator to switch. Once the generator reports a stable clock and the stabilisation delay has passed, it raises clock enable, waits the exit time and issues a DLL-reset mode-register command. Up to a parameterised number of further mode-register writes follow, for example new latency or write-recovery settings. The sequence ends with a DLL relock wait and a one-cycle completion pulse.

Every delay is a run-time cycle count. A delay of zero is treated as one cycle. While the block is idle, termination follows the controller's normal request and clock enable is high. A request that arrives while the banks are not all precharged is refused with a one-cycle reject pulse. The sequence is the same for fast-exit and slow-exit power-down.

Top module: `freqchg_seq`

## Requirements
- R1: Reset state: cke=1, busy=0, done=0, rejected=0, clk_switch_req=0, command NOP, with mode-register address and bank zero.
- R2: While idle, the odt output equals odt_norm in the same cycle, and cke is 1.
- R3: The first cycle after an accepted request, odt goes to 0 while cke stays 1. This lasts max(t_aof,1) cycles, and only then does cke fall.
- R4: cke stays low for max(t_cksre,1) cycles before clk_switch_req rises. clk_switch_req then stays high until clk_stable is sampled high at a clock edge, and it drops in the next cycle.
- R5: odt and cke stay 0 while the switch is in progress. After clk_stable is seen, they stay 0 for max(t_cksrx,1) more cycles, and then cke rises.
- R6: After cke rises, max(t_xp,1) NOP cycles pass. Then a single-cycle MRS is issued, on bank 0, with address mr0_base plus bit DLL_BIT set to 1.
- R7: Every MRS is followed by max(t_mod,1) NOP cycles. After the DLL reset, min(n_extra,MAX_MR) further MRS cycles are issued in index order. Entry k uses bank mr_banks[k*BW+:BW] and address mr_words[k*AW+:AW]. cke stays 1 and odt stays 0 throughout.
- R8: After the last MRS gap, max(t_dllk,1) NOP cycles pass with odt 0. Then done pulses for exactly one cycle with busy 0, and the block returns to idle.
- R9: cmd is either 3'b111 (NOP) or 3'b000 (MRS). In every non-MRS cycle, the mode-register address and bank are zero.
- R10: A request that arrives while busy is ignored. The sequence timing is unchanged and no reject pulse is produced.
- R11: A request while idle with pd_ok=0 produces rejected=1 in the next cycle only. No sequence starts: busy stays 0 and cke stays 1.
- R12: busy is 1 from the first cycle after an accepted request up to, but not including, the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request a clock-rate change |
| pd_ok | input | 1 | All banks precharged, so power-down entry is legal |
| odt_norm | input | 1 | Termination request from the controller, passed through when idle |
| clk_stable | input | 1 | Clock generator reports the new rate is stable |
| t_aof | input | TW | Termination-off settle cycles before cke falls |
| t_cksre | input | TW | Cycles of cke low before the clock may switch |
| t_cksrx | input | TW | Cycles of stable new clock before cke rises |
| t_xp | input | TW | Power-down exit cycles before the first command |
| t_mod | input | TW | Cycles after each mode-register command |
| t_dllk | input | TW | DLL relock cycles |
| n_extra | input | NW | Number of extra mode-register writes |
| mr0_base | input | AW | Mode-register-0 value; the DLL-reset bit is OR-ed in |
| mr_words | input | MAX_MR*AW | Packed extra mode-register values, entry 0 in the low bits |
| mr_banks | input | MAX_MR*BW | Packed extra mode-register bank selects |
| cke | output | 1 | DRAM clock enable |
| odt | output | 1 | DRAM on-die termination enable |
| cmd | output | 3 | Command {ras_n,cas_n,we_n} |
| mr_addr | output | AW | Address bus during MRS |
| mr_ba | output | BW | Bank bus during MRS |
| clk_switch_req | output | 1 | Permission to the clock generator to change rate |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | One-cycle refusal pulse |

## Verification
A wrong state register shows up within one cycle as a wrong combination of cke, odt, clk_switch_req and cmd. A wrong timer load or an off-by-one expiry moves a phase boundary, and that appears at the first edge of the affected phase. A wrong mode-register index gives a wrong address or bank on the very MRS cycle that uses it. A phase that is skipped or repeated makes the done pulse arrive early or late.

// File: rtl/freqchg_pkg.sv
package freqchg_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_ODT_OFF = 4'd1,
        S_CKE_LOW = 4'd2,
        S_SWITCH  = 4'd3,
        S_STABLE  = 4'd4,
        S_XP      = 4'd5,
        S_DLL_RST = 4'd6,
        S_MR_GAP  = 4'd7,
        S_MR_WR   = 4'd8,
        S_RELOCK  = 4'd9,
        S_DONE    = 4'd10
    } fc_state_e;

    localparam logic [2:0] CMD_NOP = 3'b111;
    localparam logic [2:0] CMD_MRS = 3'b000;

endpackage

// File: rtl/freqchg_timer.sv
module freqchg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - TW'(1);
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A loaded value of zero or one both end the phase after one cycle.
    assign expire = (cnt_q <= TW'(1));
endmodule

// File: rtl/freqchg_mr_sel.sv
module freqchg_mr_sel #(
    parameter int MAX_MR = 3,
    parameter int AW     = 14,
    parameter int BW     = 3,
    parameter int NW     = $clog2(MAX_MR + 1)
) (
    input  logic [NW-1:0]        idx,
    input  logic [MAX_MR*AW-1:0] words,
    input  logic [MAX_MR*BW-1:0] banks,
    output logic [AW-1:0]        addr,
    output logic [BW-1:0]        ba
);
    localparam int SLOTS = 2 ** NW;

    logic [AW-1:0] word_arr [SLOTS];
    logic [BW-1:0] bank_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < MAX_MR) begin : g_used
            assign word_arr[g] = words[g*AW +: AW];
            assign bank_arr[g] = banks[g*BW +: BW];
        end else begin : g_pad
            assign word_arr[g] = '0;
            assign bank_arr[g] = '0;
        end
    end

    assign addr = word_arr[idx];
    assign ba   = bank_arr[idx];
endmodule

// File: rtl/freqchg_seq.sv
module freqchg_seq
    import freqchg_pkg::*;
#(
    parameter int TW      = 8,
    parameter int AW      = 14,
    parameter int BW      = 3,
    parameter int MAX_MR  = 3,
    parameter int DLL_BIT = 8,
    parameter int NW      = $clog2(MAX_MR + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 pd_ok,
    input  logic                 odt_norm,
    input  logic                 clk_stable,
    input  logic [TW-1:0]        t_aof,
    input  logic [TW-1:0]        t_cksre,
    input  logic [TW-1:0]        t_cksrx,
    input  logic [TW-1:0]        t_xp,
    input  logic [TW-1:0]        t_mod,
    input  logic [TW-1:0]        t_dllk,
    input  logic [NW-1:0]        n_extra,
    input  logic [AW-1:0]        mr0_base,
    input  logic [MAX_MR*AW-1:0] mr_words,
    input  logic [MAX_MR*BW-1:0] mr_banks,
    output logic                 cke,
    output logic                 odt,
    output logic [2:0]           cmd,
    output logic [AW-1:0]        mr_addr,
    output logic [BW-1:0]        mr_ba,
    output logic                 clk_switch_req,
    output logic                 busy,
    output logic                 done,
    output logic                 rejected
);
    localparam logic [AW-1:0] DLL_MASK = AW'(1) << DLL_BIT;
    localparam logic [NW-1:0] MR_CAP   = NW'(MAX_MR);

    typedef struct packed {
        fc_state_e     st;
        logic [NW-1:0] idx;
        logic          rej;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_exp;
    logic [NW-1:0] n_lim;
    logic [AW-1:0] sel_addr;
    logic [BW-1:0] sel_ba;

    assign n_lim = (n_extra > MR_CAP) ? MR_CAP : n_extra;

    freqchg_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_exp)
    );

    freqchg_mr_sel #(.MAX_MR(MAX_MR), .AW(AW), .BW(BW), .NW(NW)) u_mr_sel (
        .idx   (r_q.idx),
        .words (mr_words),
        .banks (mr_banks),
        .addr  (sel_addr),
        .ba    (sel_ba)
    );

    // Next-state computation
    always_comb begin
        r_d     = r_q;
        r_d.rej = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (req) begin
                    if (pd_ok) begin
                        r_d.st = S_ODT_OFF;
                        t_load = 1'b1;
                        t_val  = t_aof;
                    end else begin
                        r_d.rej = 1'b1;
                    end
                end
            end
            S_ODT_OFF: begin
                if (t_exp) begin
                    r_d.st = S_CKE_LOW;
                    t_load = 1'b1;
                    t_val  = t_cksre;
                end
            end
            S_CKE_LOW: begin
                if (t_exp) r_d.st = S_SWITCH;
            end
            S_SWITCH: begin
                if (clk_stable) begin
                    r_d.st = S_STABLE;
                    t_load = 1'b1;
                    t_val  = t_cksrx;
                end
            end
            S_STABLE: begin
                if (t_exp) begin
                    r_d.st = S_XP;
                    t_load = 1'b1;
                    t_val  = t_xp;
                end
            end
            S_XP: begin
                if (t_exp) begin
                    r_d.st  = S_DLL_RST;
                    r_d.idx = '0;
                end
            end
            S_DLL_RST: begin
                r_d.st = S_MR_GAP;
                t_load = 1'b1;
                t_val  = t_mod;
            end
            S_MR_GAP: begin
                if (t_exp) begin
                    if (r_q.idx < n_lim) begin
                        r_d.st = S_MR_WR;
                    end else begin
                        r_d.st = S_RELOCK;
                        t_load = 1'b1;
                        t_val  = t_dllk;
                    end
                end
            end
            S_MR_WR: begin
                r_d.st  = S_MR_GAP;
                r_d.idx = r_q.idx + NW'(1);
                t_load  = 1'b1;
                t_val   = t_mod;
            end
            S_RELOCK: begin
                if (t_exp) r_d.st = S_DONE;
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_IDLE, idx: '0, rej: 1'b0};
        else        r_q <= r_d;
    end

    // Pin decode from the registered state
    always_comb begin
        cke            = 1'b1;
        odt            = 1'b0;
        cmd            = CMD_NOP;
        mr_addr        = '0;
        mr_ba          = '0;
        clk_switch_req = 1'b0;
        busy           = 1'b1;
        done           = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                odt  = odt_norm;
                busy = 1'b0;
            end
            S_CKE_LOW, S_STABLE: cke = 1'b0;
            S_SWITCH: begin
                cke            = 1'b0;
                clk_switch_req = 1'b1;
            end
            S_DLL_RST: begin
                cmd     = CMD_MRS;
                mr_addr = mr0_base | DLL_MASK;
                mr_ba   = '0;
            end
            S_MR_WR: begin
                cmd     = CMD_MRS;
                mr_addr = sel_addr;
                mr_ba   = sel_ba;
            end
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign rejected = r_q.rej;
endmodule

// File: rtl/freqchg_seq_chk.sv
module freqchg_seq_chk #(
    parameter int AW = 14,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_stable,
    input logic          cke,
    input logic          odt,
    input logic [2:0]    cmd,
    input logic [AW-1:0] mr_addr,
    input logic [BW-1:0] mr_ba,
    input logic          clk_switch_req,
    input logic          busy,
    input logic          done,
    input logic          rejected
);
    a_r3_odt_off_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!odt && $past(!odt)));

    a_r5_pins_low_in_switch: assert property (@(posedge clk) disable iff (!rst_n)
        clk_switch_req |-> (!cke && !odt));

    a_r4_switch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_switch_req && !clk_stable) |=> clk_switch_req);

    a_r7_mrs_with_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'b000) |-> (cke && !odt && busy));

    a_r9_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'b111) || (cmd == 3'b000));

    a_r9_nop_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 3'b000) |-> (mr_addr == '0 && mr_ba == '0));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && !odt));

    a_r11_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (!busy && cke));
endmodule

bind freqchg_seq freqchg_seq_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clk_stable     (clk_stable),
    .cke            (cke),
    .odt            (odt),
    .cmd            (cmd),
    .mr_addr        (mr_addr),
    .mr_ba          (mr_ba),
    .clk_switch_req (clk_switch_req),
    .busy           (busy),
    .done           (done),
    .rejected       (rejected)
);

// File: tb/freqchg_seq_test.sv
`timescale 1ns/1ps
module freqchg_seq_test;
    localparam int TW = 8, AW = 14, BW = 3, MAX_MR = 3, DLL_BIT = 8;
    localparam int NW = $clog2(MAX_MR + 1);
    localparam int VW = 26;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 1'b0, pd_ok = 1'b1, odt_norm = 1'b1, clk_stable = 1'b0;
    logic [TW-1:0] t_aof, t_cksre, t_cksrx, t_xp, t_mod, t_dllk;
    logic [NW-1:0] n_extra;
    logic [AW-1:0] mr0_base = 14'h0520;
    logic [MAX_MR*AW-1:0] mr_words = {14'h1333, 14'h1222, 14'h1111};
    logic [MAX_MR*BW-1:0] mr_banks = {3'd3, 3'd2, 3'd1};
    logic cke, odt, clk_switch_req, busy, done, rejected;
    logic [2:0] cmd;
    logic [AW-1:0] mr_addr;
    logic [BW-1:0] mr_ba;

    int checks = 0, fails = 0, cycles = 0;
    logic [VW-1:0] e_vec [128];
    string         e_tag [128];
    int            nexp;

    always #4 clk = ~clk;

    freqchg_seq #(.TW(TW), .AW(AW), .BW(BW), .MAX_MR(MAX_MR), .DLL_BIT(DLL_BIT)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .pd_ok(pd_ok), .odt_norm(odt_norm),
        .clk_stable(clk_stable), .t_aof(t_aof), .t_cksre(t_cksre), .t_cksrx(t_cksrx),
        .t_xp(t_xp), .t_mod(t_mod), .t_dllk(t_dllk), .n_extra(n_extra),
        .mr0_base(mr0_base), .mr_words(mr_words), .mr_banks(mr_banks),
        .cke(cke), .odt(odt), .cmd(cmd), .mr_addr(mr_addr), .mr_ba(mr_ba),
        .clk_switch_req(clk_switch_req), .busy(busy), .done(done), .rejected(rejected));

    function automatic logic [VW-1:0] pack(bit k, bit o, bit s, bit m, logic [AW-1:0] a,
                                            logic [BW-1:0] b, bit dn, bit bz, bit rj);
        return {k, o, s, (m ? 3'b000 : 3'b111), a, b, dn, bz, rj};
    endfunction

    function automatic int mx1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic logic [VW-1:0] observed();
        return {cke, odt, clk_switch_req, cmd, mr_addr, mr_ba, done, busy, rejected};
    endfunction

    task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic add(int len, string tag, logic [VW-1:0] v);
        for (int i = 0; i < len; i++) begin
            nexp++;
            e_vec[nexp] = v;
            e_tag[nexp] = tag;
        end
    endtask

    // Drives one full sequence and compares every cycle to a computed schedule
    task automatic run_seq(int aof, int sre, int srx, int xp, int md, int dk, int nx,
                           int dly, bit poke);
        int sw_start;
        t_aof = TW'(aof); t_cksre = TW'(sre); t_cksrx = TW'(srx);
        t_xp = TW'(xp); t_mod = TW'(md); t_dllk = TW'(dk); n_extra = NW'(nx);
        nexp = 0;
        add(mx1(aof), "R3", pack(1, 0, 0, 0, '0, '0, 0, 1, 0));
        add(mx1(sre), "R4", pack(0, 0, 0, 0, '0, '0, 0, 1, 0));
        sw_start = nexp + 1;
        add(dly + 1, "R4", pack(0, 0, 1, 0, '0, '0, 0, 1, 0));
        add(mx1(srx), "R5", pack(0, 0, 0, 0, '0, '0, 0, 1, 0));
        add(mx1(xp), "R6", pack(1, 0, 0, 0, '0, '0, 0, 1, 0));
        add(1, "R6", pack(1, 0, 0, 1, mr0_base | (AW'(1) << DLL_BIT), '0, 0, 1, 0));
        for (int k = 0; k <= nx; k++) begin
            add(mx1(md), "R7", pack(1, 0, 0, 0, '0, '0, 0, 1, 0));
            if (k < nx)
                add(1, "R7", pack(1, 0, 0, 1, mr_words[k*AW +: AW], mr_banks[k*BW +: BW], 0, 1, 0));
        end
        add(mx1(dk), "R8", pack(1, 0, 0, 0, '0, '0, 0, 1, 0));
        add(1, "R8", pack(1, 0, 0, 0, '0, '0, 1, 0, 0));

        @(negedge clk);
        clk_stable = 1'b0;
        req = 1'b1;
        pd_ok = 1'b1;
        for (int i = 1; i <= nexp; i++) begin
            @(negedge clk);
            check(e_tag[i], observed(), e_vec[i]);
            req = 1'b0;
            if (poke && i == 2) begin   // R10: request while busy
                req = 1'b1;
                pd_ok = 1'b0;
            end
            if (poke && i == 3) pd_ok = 1'b1;
            if (i == sw_start + dly) clk_stable = 1'b1;
        end
        pd_ok = 1'b1;
        @(negedge clk);
        check("R2", observed(), pack(1, 1, 0, 0, '0, '0, 0, 0, 0));
        clk_stable = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int run = 0;
        int pairs_md[2] = '{1, 2};
        int pairs_dk[2] = '{0, 5};
        int vals3[3]    = '{0, 1, 2};
        int sre_v[3]    = '{0, 1, 3};
        int nx_v[3]     = '{0, 1, 3};
        t_aof = '0; t_cksre = '0; t_cksrx = '0; t_xp = '0; t_mod = '0; t_dllk = '0;
        n_extra = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", observed(), pack(1, 1, 0, 0, '0, '0, 0, 0, 0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", observed(), pack(1, 1, 0, 0, '0, '0, 0, 0, 0));
        // R2 idle pass-through of termination
        odt_norm = 1'b0;
        #1 check("R2", observed(), pack(1, 0, 0, 0, '0, '0, 0, 0, 0));
        odt_norm = 1'b1;
        #1 check("R2", observed(), pack(1, 1, 0, 0, '0, '0, 0, 0, 0));
        // R11 refused request
        @(negedge clk);
        req = 1'b1; pd_ok = 1'b0;
        @(negedge clk);
        req = 1'b0; pd_ok = 1'b1;
        check("R11", observed(), pack(1, 1, 0, 0, '0, '0, 0, 0, 1));
        @(negedge clk);
        check("R11", observed(), pack(1, 1, 0, 0, '0, '0, 0, 0, 0));
        // R3..R8, R10, R12: sweep of delays, write counts and switch latency
        foreach (vals3[a])
            foreach (sre_v[b])
                for (int c = 0; c < 2; c++)
                    foreach (vals3[x])
                        foreach (nx_v[n])
                            for (int p = 0; p < 2; p++) begin
                                run_seq(vals3[a], sre_v[b], c * 2, vals3[x], pairs_md[p],
                                        pairs_dk[p], nx_v[n], run % 3, (run % 4) == 0);
                                run++;
                            end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule